// File: doc/BRIEF.md
# Controlled Modular Multiplier

This block multiplies an operand `x` by a fixed constant `MULT` modulo a fixed `MODULUS`, under the control of a single enable bit. When the control bit is 1, the result is `MULT·x mod MODULUS`. When the control bit is 0, the result is a plain copy of `x`. The product is built one bit of `x` at a time. For each bit there are three steps. First, a scratch register is loaded with the precomputed stage constant `(2^i·MULT) mod MODULUS`, but only when both the control bit and bit `i` of `x` are 1. Second, the scratch value is added modulo `MODULUS` into a result register that starts at zero. Third, the same conditional load pattern is applied again, which returns the scratch register to zero.

Every bit update of the scratch and result registers is a reversible XOR with an AND of control terms. As a result, the scratch register is left clean at the end of every stage. After the last stage, a conditional copy with an inverted control writes `x` into the result only when the control bit is 0. The stage constants are computed from the parameters during elaboration. An operation is launched with a one-cycle `start` and ends with a one-cycle `done` pulse.

Top module: `cmm_top`

## Requirements
- R1: After reset, `done` and `busy` are 0, and `result` and `scratch` are 0.
- R2: With `ctl`=1 at start, `result` at `done` equals `(MULT·x) mod MODULUS` for every `x` in 0..2^WIDTH-1.
- R3: With `ctl`=0 at start, `result` at `done` equals `x` bit for bit.
- R4: `scratch` is 0 whenever `done` is high, and 0 in the cycle after every clear step of a stage.
- R5: `done` rises exactly 3·WIDTH+1 clock edges after the edge that accepts `start`. It stays high for exactly one cycle, and `busy` is high from the edge after the accepting edge until `done`.
- R6: While an operation with `ctl`=1 is running, `result` never reaches `MODULUS` or more.
- R7: A `start` pulse, or a change of `ctl` or `x`, while `busy` is high has no effect on the operation in progress. When the block is idle and `start` is low, `result` holds its value.
- R8: In the add step of stage `i`, `scratch` holds `(2^i·MULT) mod MODULUS` if `ctl` and `x[i]` were both 1 at start, and holds 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, accepted only while idle |
| ctl | input | 1 | Control bit: 1 multiplies, 0 copies |
| x | input | WIDTH | Operand, sampled on the accepting edge |
| result | output | WIDTH | Result register |
| scratch | output | WIDTH | Scratch register that holds the stage constant |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a new `start` arriving, with a different operand and control bit, in the middle of a run. The stimulus covers it by pulsing `start` with altered `ctl` and `x` several cycles after launch. It then checks that the result still matches the first operand. The full grid of `ctl` and every value of `x` in the small default configuration is swept, including operands of `MODULUS` or more. This exercises every stage constant and every wrap of the modular add. It also covers the case where the copy step must leave the multiplied result untouched.

// File: rtl/cmm_pkg.sv
package cmm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_ADD   = 3'd2,
    ST_CLEAR = 3'd3,
    ST_COPY  = 3'd4,
    ST_DONE  = 3'd5
  } cmm_state_e;

  // (2^i * mult) mod modulus, doubling one step at a time
  function automatic int unsigned stage_const(int unsigned mult, int unsigned modulus,
                                              int unsigned i);
    int unsigned v;
    v = mult % modulus;
    for (int unsigned k = 0; k < i; k++) v = (2 * v) % modulus;
    return v;
  endfunction

endpackage

// File: rtl/cmm_const_rom.sv
module cmm_const_rom #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 13,
  parameter int MULT    = 7,
  parameter int STAGES  = 4,
  parameter int IDX_W   = 2
) (
  input  logic [IDX_W-1:0] idx,
  output logic [WIDTH-1:0] value
);
  logic [WIDTH-1:0] tab [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_tab
    assign tab[g] = WIDTH'(cmm_pkg::stage_const(MULT, MODULUS, g));
  end

  always_comb begin
    value = '0;
    for (int k = 0; k < STAGES; k++)
      if (idx == IDX_W'(k)) value = tab[k];
  end
endmodule

// File: rtl/cmm_toffoli_row.sv
module cmm_toffoli_row #(
  parameter int WIDTH = 4
) (
  input  logic             ctl_a,
  input  logic             ctl_b,
  input  logic [WIDTH-1:0] pattern,
  input  logic [WIDTH-1:0] target,
  output logic [WIDTH-1:0] next
);
  // One controlled-controlled flip per bit where the pattern has a 1
  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    assign next[j] = target[j] ^ (ctl_a & ctl_b & pattern[j]);
  end
endmodule

// File: rtl/cmm_modadd.sv
module cmm_modadd #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 13
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum
);
  localparam logic [WIDTH:0] MOD_EXT = (WIDTH+1)'(MODULUS);
  logic [WIDTH:0] raw;

  assign raw = {1'b0, a} + {1'b0, b};
  assign sum = (raw >= MOD_EXT) ? WIDTH'(raw - MOD_EXT) : raw[WIDTH-1:0];
endmodule

// File: rtl/cmm_top.sv
module cmm_top #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 13,
  parameter int MULT    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ctl,
  input  logic [WIDTH-1:0] x,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] scratch,
  output logic             busy,
  output logic             done
);
  import cmm_pkg::*;

  localparam int STAGES = WIDTH;
  localparam int IDX_W  = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STAGES - 1);

  cmm_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             c_q;
  logic [WIDTH-1:0] x_q;
  logic [WIDTH-1:0] result_q;
  logic [WIDTH-1:0] scratch_q;

  // Named internal events, visible to the bound checker
  logic evt_accept, evt_load, evt_add, evt_clear, evt_copy;
  logic x_bit;
  logic [WIDTH-1:0] stage_k, scratch_flip, sum_next, copy_next;

  assign evt_accept = (state_q == ST_IDLE) && start;
  assign evt_load   = (state_q == ST_LOAD);
  assign evt_add    = (state_q == ST_ADD);
  assign evt_clear  = (state_q == ST_CLEAR);
  assign evt_copy   = (state_q == ST_COPY);
  assign x_bit      = x_q[idx_q];

  cmm_const_rom #(.WIDTH(WIDTH), .MODULUS(MODULUS), .MULT(MULT),
                  .STAGES(STAGES), .IDX_W(IDX_W)) u_rom (
    .idx(idx_q), .value(stage_k));

  cmm_toffoli_row #(.WIDTH(WIDTH)) u_scratch_row (
    .ctl_a(c_q), .ctl_b(x_bit), .pattern(stage_k),
    .target(scratch_q), .next(scratch_flip));

  cmm_modadd #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_add (
    .a(result_q), .b(scratch_q), .sum(sum_next));

  cmm_toffoli_row #(.WIDTH(WIDTH)) u_copy_row (
    .ctl_a(~c_q), .ctl_b(1'b1), .pattern(x_q),
    .target(result_q), .next(copy_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      c_q       <= 1'b0;
      x_q       <= '0;
      result_q  <= '0;
      scratch_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          c_q       <= ctl;
          x_q       <= x;
          result_q  <= '0;
          scratch_q <= '0;
          idx_q     <= '0;
          state_q   <= ST_LOAD;
        end
        ST_LOAD: begin
          scratch_q <= scratch_flip;
          state_q   <= ST_ADD;
        end
        ST_ADD: begin
          result_q <= sum_next;
          state_q  <= ST_CLEAR;
        end
        ST_CLEAR: begin
          scratch_q <= scratch_flip;
          if (idx_q == LAST_IDX) state_q <= ST_COPY;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_LOAD;
          end
        end
        ST_COPY: begin
          result_q <= copy_next;
          state_q  <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign result  = result_q;
  assign scratch = scratch_q;
  assign busy    = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done    = (state_q == ST_DONE);
endmodule

// File: rtl/cmm_checker.sv
module cmm_checker #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 13,
  parameter int MULT    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result,
  input logic [WIDTH-1:0] scratch,
  input logic             c_q,
  input logic [WIDTH-1:0] x_q,
  input logic             x_bit,
  input logic [WIDTH-1:0] stage_k,
  input logic             evt_accept,
  input logic             evt_add,
  input logic             evt_clear,
  input logic             evt_copy
);
  localparam logic [WIDTH:0] MOD_EXT = (WIDTH+1)'(MODULUS);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> busy); // R5

  AST_SCRATCH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scratch == '0)); // R4

  AST_SCRATCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clear |=> (scratch == '0)); // R4

  AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && c_q) |-> ({1'b0, result} < MOD_EXT)); // R6

  AST_COPY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_copy && !c_q) |=> (result == $past(x_q))); // R3

  AST_COPY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_copy && c_q) |=> $stable(result)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result)); // R7

  AST_STAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_add |-> (scratch == ((c_q && x_bit) ? stage_k : '0))); // R8
endmodule

bind cmm_top cmm_checker #(.WIDTH(WIDTH), .MODULUS(MODULUS), .MULT(MULT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .scratch(scratch), .c_q(c_q), .x_q(x_q), .x_bit(x_bit),
  .stage_k(stage_k), .evt_accept(evt_accept), .evt_add(evt_add),
  .evt_clear(evt_clear), .evt_copy(evt_copy));

// File: tb/sim_cmm_top.sv
`timescale 1ns/1ps
module sim_cmm_top;
  localparam int W = 4;
  localparam int M = 13;
  localparam int A = 7;
  localparam int LAT = 3 * W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ctl = 1'b0;
  logic [W-1:0] x = '0;
  logic [W-1:0] result, scratch;
  logic busy, done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cmm_top #(.WIDTH(W), .MODULUS(M), .MULT(A)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl(ctl), .x(x),
    .result(result), .scratch(scratch), .busy(busy), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Launch one run; optionally disturb inputs mid-run. Returns edge count to done.
  task automatic run(input bit c, input int xv, input bit disturb, output int edges);
    @(negedge clk);
    ctl = c; x = W'(xv); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    check(busy == 1'b1, "R5 busy after accept", busy, 1);
    while (edges < 100) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (disturb && edges == 4) begin
        ctl = ~c; x = ~W'(xv); start = 1'b1;
      end else if (disturb && edges == 5) begin
        start = 1'b0;
      end
      if (done) break;
    end
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int edges;
    int expv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(done == 0 && busy == 0, "R1 flags", {busy, done}, 0);
    check(result == 0 && scratch == 0, "R1 registers", {result, scratch}, 0);
    rst_n = 1'b1;

    for (int c = 0; c < 2; c++) begin
      for (int xv = 0; xv < (1 << W); xv++) begin
        run(c[0], xv, 1'b0, edges);
        expv = c ? (A * xv) % M : xv;
        if (c) check(result == W'(expv), "R2 product", result, expv);
        else   check(result == W'(expv), "R3 copy", result, expv);
        check(scratch == 0, "R4 scratch at done", scratch, 0);
        check(edges == LAT, "R5 latency", edges, LAT);
        @(negedge clk);
        check(done == 0, "R5 single pulse", done, 0);
        // R7 idle hold: result unchanged with start low
        repeat (2) @(negedge clk);
        check(result == W'(expv), "R7 idle hold", result, expv);
      end
    end

    // R7 disturbance while busy: original operands must win
    run(1'b1, 11, 1'b1, edges);
    check(result == W'((A * 11) % M), "R7 mid-run start ignored", result, (A * 11) % M);
    check(edges == LAT, "R7 latency unchanged", edges, LAT);
    run(1'b0, 9, 1'b1, edges);
    check(result == W'(9), "R7 mid-run ctl ignored", result, 9);

    // R8 observe scratch during a stage via ports: stage 0 add step with x=1, ctl=1
    @(negedge clk);
    ctl = 1'b1; x = W'(1); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    @(posedge clk); @(negedge clk);
    check(scratch == W'(A % M), "R8 stage0 constant", scratch, A % M);
    @(posedge clk); @(negedge clk);
    check(result == W'(A % M), "R6 partial sum", result, A % M);
    @(posedge clk); @(negedge clk);
    check(scratch == 0, "R4 cleared after stage", scratch, 0);
    @(posedge clk); @(negedge clk);
    check(scratch == 0, "R8 stage1 bit clear", scratch, 0);
    while (!done) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule